// File: doc/BRIEF.md
# In-Order Reservation Station with Forwarding Capture

This block sits between an operation dispatcher and a single execution unit. It accepts at most one operation per clock. Each operation carries two source operands. Each operand arrives either as a value or as a rename tag for a result that has not been produced yet. Accepted operations wait in a small FIFO of two or four entries.

Each waiting operand watches a set of result-forwarding buses, one for general results and one for load data. It captures the value whose tag matches. Operations leave strictly from the head of the FIFO. The head leaves only when both of its operands hold values and the execution unit says it is free.

An operation that arrives at an empty station with both operands usable, while the unit is free, goes straight to the issue port in the same clock and is never stored. A flush input drops everything in one clock.

Top module: `fifo_rsv_station`

## Requirements
- R1: `DEPTH` is 2 or 4. The station never holds more than `DEPTH` entries. `disp_ready` is low exactly while `DEPTH` entries are stored.
- R2: At most one operation is accepted per clock. A dispatch presented while `disp_ready` is low is discarded: it is never stored and never issued.
- R3: Operations issue in arrival order. Only the oldest stored entry may issue. A ready younger entry waits behind a head that is not ready.
- R4: `iss_valid` is never high while `unit_free` is low. A ready head issues in the first clock in which `unit_free` is high.
- R5: When the station is empty and both incoming operands are usable, a dispatch with `unit_free` high appears on the issue port in the same clock with its own values, and it is not stored.
- R6: A stored operand waiting on tag T takes the data from any forwarding bus `k` that shows `fwd_valid[k]` with tag T. Its entry can issue from the following clock onward.
- R7: A forwarding value with a matching tag in the same clock as the dispatch counts for the incoming operation. This holds both for the same-clock bypass and for an operation that gets stored.
- R8: If several buses carry the same tag in one clock, the lowest-numbered bus supplies the value. Bus 0 occupies bits [TAG_W-1:0] and [DATA_W-1:0] of the packed buses.
- R9: While `flush` is high, nothing issues and any dispatch in that clock is dropped. From the next clock on, the station is empty.
- R10: After reset the station is empty, `disp_ready` is high and `iss_valid` is low.
- R11: An operand that already holds a value keeps it when its tag appears again on a bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries; no issue this clock |
| disp_valid | input | 1 | Dispatcher presents an operation |
| disp_ready | output | 1 | Station has a free entry |
| disp_op | input | OP_W | Operation code |
| disp_a_rdy | input | 1 | Operand A carries a value |
| disp_a_tag | input | TAG_W | Operand A rename tag |
| disp_a_val | input | DATA_W | Operand A value |
| disp_b_rdy | input | 1 | Operand B carries a value |
| disp_b_tag | input | TAG_W | Operand B rename tag |
| disp_b_val | input | DATA_W | Operand B value |
| fwd_valid | input | NFWD | Forwarding bus valid, one bit per bus |
| fwd_tag | input | NFWD*TAG_W | Forwarding bus tags, bus k at bits [k*TAG_W +: TAG_W] |
| fwd_data | input | NFWD*DATA_W | Forwarding bus data, bus k at bits [k*DATA_W +: DATA_W] |
| unit_free | input | 1 | Execution unit can take an operation |
| iss_valid | output | 1 | An operation is issued this clock |
| iss_op | output | OP_W | Issued operation code |
| iss_a | output | DATA_W | Issued operand A value |
| iss_b | output | DATA_W | Issued operand B value |

## Verification
The bench fills the station while the unit is busy and then attempts one more dispatch. A design that let that extra operation in would overwrite the oldest entry or issue a stray operation. A ready entry queued behind a waiting head must stay put; a design that picked the oldest ready entry would issue it out of order. Forwarding values are presented in the dispatch clock itself, on both buses at once, and again after capture. This exposes lost wakeups, the wrong bus winning, and captured data being overwritten. A flush with a concurrent dispatch, followed by a bypass, shows whether flushed entries linger or the flush clock leaks an issue.

// File: rtl/fifo_rsv_station.sv
module fifo_rsv_station #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int NFWD   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [OP_W-1:0]        disp_op,
  input  logic                   disp_a_rdy,
  input  logic [TAG_W-1:0]       disp_a_tag,
  input  logic [DATA_W-1:0]      disp_a_val,
  input  logic                   disp_b_rdy,
  input  logic [TAG_W-1:0]       disp_b_tag,
  input  logic [DATA_W-1:0]      disp_b_val,
  input  logic [NFWD-1:0]        fwd_valid,
  input  logic [NFWD*TAG_W-1:0]  fwd_tag,
  input  logic [NFWD*DATA_W-1:0] fwd_data,
  input  logic                   unit_free,
  output logic                   iss_valid,
  output logic [OP_W-1:0]        iss_op,
  output logic [DATA_W-1:0]      iss_a,
  output logic [DATA_W-1:0]      iss_b
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [OP_W-1:0]   op_q [DEPTH];
  logic [TAG_W-1:0]  at_q [DEPTH];
  logic [TAG_W-1:0]  bt_q [DEPTH];
  logic [DATA_W-1:0] ad_q [DEPTH];
  logic [DATA_W-1:0] bd_q [DEPTH];
  logic [DEPTH-1:0]  av_q, bv_q;
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [DATA_W:0] snoop(input logic [TAG_W-1:0] tag);
    logic [DATA_W:0] r;
    r = '0;
    for (int k = NFWD - 1; k >= 0; k--)
      if (fwd_valid[k] && fwd_tag[k*TAG_W +: TAG_W] == tag)
        r = {1'b1, fwd_data[k*DATA_W +: DATA_W]};
    return r;
  endfunction

  logic [DATA_W:0] in_a, in_b;
  logic [DATA_W:0] a_snp [DEPTH];
  logic [DATA_W:0] b_snp [DEPTH];
  logic empty, full, take, head_ok, pop, bypass, push;
  logic [PTR_W-1:0] tail;

  assign in_a = disp_a_rdy ? {1'b1, disp_a_val} : snoop(disp_a_tag);
  assign in_b = disp_b_rdy ? {1'b1, disp_b_val} : snoop(disp_b_tag);

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      a_snp[i] = snoop(at_q[i]);
      b_snp[i] = snoop(bt_q[i]);
    end

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign disp_ready = !full;
  assign take       = disp_valid && !full && !flush;
  assign head_ok    = !empty && av_q[head_q] && bv_q[head_q];
  assign pop        = head_ok && unit_free && !flush;
  assign bypass     = empty && take && in_a[DATA_W] && in_b[DATA_W] && unit_free;
  assign push       = take && !bypass;
  assign tail       = head_q + PTR_W'(cnt_q);

  assign iss_valid = pop || bypass;
  assign iss_op    = bypass ? disp_op            : op_q[head_q];
  assign iss_a     = bypass ? in_a[DATA_W-1:0]   : ad_q[head_q];
  assign iss_b     = bypass ? in_b[DATA_W-1:0]   : bd_q[head_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      av_q   <= '0;
      bv_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i] <= '0;
        at_q[i] <= '0;
        bt_q[i] <= '0;
        ad_q[i] <= '0;
        bd_q[i] <= '0;
      end
    end else if (flush) begin
      cnt_q <= '0;
      av_q  <= '0;
      bv_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!av_q[i] && a_snp[i][DATA_W]) begin
          av_q[i] <= 1'b1;
          ad_q[i] <= a_snp[i][DATA_W-1:0];
        end
        if (!bv_q[i] && b_snp[i][DATA_W]) begin
          bv_q[i] <= 1'b1;
          bd_q[i] <= b_snp[i][DATA_W-1:0];
        end
      end
      if (push) begin
        op_q[tail] <= disp_op;
        av_q[tail] <= in_a[DATA_W];
        at_q[tail] <= disp_a_tag;
        ad_q[tail] <= in_a[DATA_W-1:0];
        bv_q[tail] <= in_b[DATA_W];
        bt_q[tail] <= disp_b_tag;
        bd_q[tail] <= in_b[DATA_W-1:0];
      end
      if (pop) head_q <= head_q + PTR_W'(1);
      if (push && !pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop && !push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic             unit_free,
  input logic             iss_valid,
  input logic [CNT_W-1:0] cnt
);
  initial a_r1_depth_legal: assert (DEPTH == 2 || DEPTH == 4);

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  a_r2_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(cnt) <= int'($past(cnt)) + 1);

  a_r2_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) == DEPTH && !iss_valid && !flush) |=> int'(cnt) == DEPTH);

  a_r4_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> unit_free);

  a_r5_bypass_source: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && cnt == '0) |-> disp_valid);

  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !iss_valid);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && disp_ready));
endmodule

bind fifo_rsv_station rsv_station_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .unit_free(unit_free), .iss_valid(iss_valid), .cnt(cnt_q)
);

// File: tb/fifo_rsv_station_tb_top.sv
`timescale 1ns/1ps
module fifo_rsv_station_tb_top;
  localparam int OP_W = 4, DW = 16, TW = 4;

  logic clk = 0, rst_n = 0, flush = 0;
  logic disp_valid = 0, disp_ready;
  logic [OP_W-1:0] disp_op = '0;
  logic disp_a_rdy = 0, disp_b_rdy = 0;
  logic [TW-1:0] disp_a_tag = '0, disp_b_tag = '0;
  logic [DW-1:0] disp_a_val = '0, disp_b_val = '0;
  logic [1:0] fwd_valid = '0;
  logic [2*TW-1:0] fwd_tag = '0;
  logic [2*DW-1:0] fwd_data = '0;
  logic unit_free = 0, iss_valid;
  logic [OP_W-1:0] iss_op;
  logic [DW-1:0] iss_a, iss_b;

  int total = 0, fails = 0;
  bit done = 0;
  logic [OP_W+2*DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  fifo_rsv_station dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && iss_valid) begin
      if (exp_q.size() == 0) chk(0, "R2/R3 unexpected issue", {iss_op, iss_a, iss_b}, 0);
      else begin
        automatic logic [OP_W+2*DW-1:0] e = exp_q.pop_front();
        chk({iss_op, iss_a, iss_b} == e, "R3 issue order/data", {iss_op, iss_a, iss_b}, e);
      end
    end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic look(); #4; endtask
  task automatic expect_issue(input logic [OP_W-1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    exp_q.push_back({op, a, b});
  endtask
  task automatic disp(input logic [OP_W-1:0] op, input bit ar, input logic [TW-1:0] at, input logic [DW-1:0] av,
                      input bit br, input logic [TW-1:0] bt, input logic [DW-1:0] bv);
    disp_valid = 1; disp_op = op;
    disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
    disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
  endtask
  task automatic idle(); disp_valid = 0; fwd_valid = '0; endtask
  task automatic fwd(input int k, input logic [TW-1:0] t, input logic [DW-1:0] d);
    fwd_valid[k] = 1; fwd_tag[k*TW +: TW] = t; fwd_data[k*DW +: DW] = d;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look();
    chk(disp_ready == 1, "R10 ready after reset", disp_ready, 1);
    chk(iss_valid == 0, "R10 no issue after reset", iss_valid, 0);

    // R5 bypass
    cyc(); unit_free = 1; disp(1, 1, 0, 16'h11, 1, 0, 16'h22); expect_issue(1, 16'h11, 16'h22);
    look(); chk(iss_valid == 1, "R5 same-clock bypass", iss_valid, 1);
    cyc(); idle(); look(); chk(iss_valid == 0, "R5 bypassed op not stored", iss_valid, 0);

    // R7 same-clock capture on bypass
    cyc(); disp(2, 0, 3, 0, 1, 0, 16'h34); fwd(0, 3, 16'h33); expect_issue(2, 16'h33, 16'h34);
    look(); chk(iss_valid && iss_a == 16'h33, "R7 bypass with forwarded operand", iss_a, 16'h33);
    // R7 same-clock capture into stored entry
    cyc(); idle(); unit_free = 0; disp(3, 0, 4, 0, 1, 0, 16'h3B); fwd(0, 4, 16'h44);
    look(); chk(iss_valid == 0, "R4 no issue while unit busy", iss_valid, 0);
    cyc(); idle(); unit_free = 1; expect_issue(3, 16'h44, 16'h3B);
    look(); chk(iss_valid && iss_a == 16'h44, "R7 stored entry kept dispatch-clock forward", iss_a, 16'h44);

    // R1/R2/R3 fill and overflow attempt
    cyc(); idle(); unit_free = 0;
    for (int i = 0; i < 4; i++) begin
      disp(OP_W'(4 + i), 1, 0, DW'(16'h40 + i), 1, 0, DW'(16'h50 + i));
      expect_issue(OP_W'(4 + i), DW'(16'h40 + i), DW'(16'h50 + i));
      look(); chk(disp_ready == 1, "R1 ready while not full", disp_ready, 1);
      cyc();
    end
    disp(15, 1, 0, 16'hFFFF, 1, 0, 16'hFFFF);
    look(); chk(disp_ready == 0, "R1 not ready when full", disp_ready, 0);
    chk(iss_valid == 0, "R4 full station waits for unit", iss_valid, 0);
    cyc(); idle(); unit_free = 1;
    for (int i = 0; i < 4; i++) begin
      look(); chk(iss_valid && iss_op == OP_W'(4 + i), "R3 drain in arrival order", iss_op, 4 + i);
      cyc();
    end
    look(); chk(iss_valid == 0 && exp_q.size() == 0, "R2 dispatch while full discarded", exp_q.size(), 0);

    // R3/R6 head blocking and load-bus wakeup
    cyc(); disp(8, 0, 5, 0, 1, 0, 16'h08); expect_issue(8, 16'h55, 16'h08);
    look(); chk(iss_valid == 0, "R5 not-ready op is stored", iss_valid, 0);
    cyc(); disp(9, 1, 0, 16'h91, 1, 0, 16'h92); expect_issue(9, 16'h91, 16'h92);
    look(); chk(iss_valid == 0, "R3 ready younger waits behind head", iss_valid, 0);
    cyc(); idle(); fwd(1, 5, 16'h55);
    look(); chk(iss_valid == 0, "R6 capture visible next clock", iss_valid, 0);
    cyc(); idle(); look(); chk(iss_valid && iss_op == 8, "R6 head issues after load capture", iss_op, 8);
    cyc(); look(); chk(iss_valid && iss_op == 9, "R3 younger follows", iss_op, 9);
    cyc(); look(); chk(iss_valid == 0, "R3 station drained", iss_valid, 0);

    // R8 bus priority
    cyc(); disp(10, 1, 0, 16'hA0, 0, 6, 0); expect_issue(10, 16'hA0, 16'h60);
    cyc(); idle(); fwd(0, 6, 16'h60); fwd(1, 6, 16'h61);
    cyc(); idle(); look(); chk(iss_valid && iss_b == 16'h60, "R8 lowest bus wins", iss_b, 16'h60);

    // R11 no overwrite after capture
    cyc(); disp(11, 0, 7, 0, 0, 8, 0); expect_issue(11, 16'h70, 16'h80);
    cyc(); idle(); fwd(0, 7, 16'h70);
    cyc(); idle(); fwd(0, 7, 16'h7F);
    look(); chk(iss_valid == 0, "R4 waits for second operand", iss_valid, 0);
    cyc(); idle(); fwd(1, 8, 16'h80);
    cyc(); idle(); look(); chk(iss_valid && iss_a == 16'h70, "R11 captured value kept", iss_a, 16'h70);

    // R9 flush
    cyc(); idle(); unit_free = 0; disp(12, 1, 0, 16'hC0, 1, 0, 16'hC1);
    cyc(); disp(13, 1, 0, 16'hD0, 1, 0, 16'hD1);
    cyc(); flush = 1; unit_free = 1; disp(14, 1, 0, 16'hE0, 1, 0, 16'hE1);
    look(); chk(iss_valid == 0, "R9 no issue during flush", iss_valid, 0);
    cyc(); flush = 0; idle();
    look(); chk(iss_valid == 0 && disp_ready == 1, "R9 empty after flush", iss_valid, 0);
    cyc(); disp(1, 1, 0, 16'h0101, 1, 0, 16'h0202); expect_issue(1, 16'h0101, 16'h0202);
    look(); chk(iss_valid && iss_op == 1, "R9 bypass proves station empty", iss_op, 1);
    cyc(); idle();
    look(); chk(iss_valid == 0 && exp_q.size() == 0, "R9 flushed ops never issue", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule